// File: doc/BRIEF.md
# Monochrome glyph expansion unit

This block turns one-bit-per-pixel glyph or bitmap rows into 32-bit color pixels for a frame buffer. A host first programs a packed start coordinate, a span width of 1 to 32 pixels, a packed (Y,X) increment and a foreground/background color pair. It then writes one 32-bit mask word per glyph row. The block walks that word from its most significant bit, issuing one pixel per clock to a frame-buffer write port: foreground for a set bit, background for a clear bit. The bits beyond the span width are dropped.

After the last pixel of a row, the coordinate register steps by the increment, with the X and Y halves added independently. A run of mask writes therefore fills successive rows, or any other pattern the increment describes. While a row is still being issued the block holds its write-ready low, and the host keeps its write pending until ready returns.

Top module: `glyph_expand_top`

## Requirements
- R1: After reset, `px_valid` is 0 and `reg_ready` is 1.
- R2: A host write is accepted on a rising clock edge where `reg_wr` and `reg_ready` are both 1. `reg_sel` selects the target: 0 is the coordinate, 1 is the span width, 2 is the increment, 3 is the color pair and 4 is a row mask word.
- R3: The coordinate write carries Y in bits 31:16 and X in bits 15:0. The first pixel of the next row is issued at that (X,Y).
- R4: A mask write accepted at edge E issues pixels on consecutive cycles, with pixel k valid in the cycle after edge E+k. Pixel k takes mask bit 31-k, and its X is the coordinate X plus k, modulo 2^16. All pixels of a row share the coordinate Y.
- R5: A set mask bit issues the foreground color and a clear bit issues the background color. The color-pair write carries the foreground in bits 63:32 and the background in bits 31:0.
- R6: The span width is taken from bits 4:0 of its write. The values 1 to 31 issue exactly that many pixels and 0 issues 32. For example, a written 32 issues 32 pixels and a written 33 issues 1 pixel. Mask bits beyond the span produce no pixel.
- R7: When a row's last pixel is issued, the coordinate steps by the increment. The increment carries the Y step in bits 31:16 and the X step in bits 15:0, and each half is added modulo 2^16 with no carry between them.
- R8: `reg_ready` is 0 from the cycle after a mask write is accepted until the row's last pixel has been issued. A write presented during that time has no effect.
- R9: With an increment of 0x0001_0000, successive mask words draw at the same X on successive Y rows.
- R10: Writes with `reg_sel` 5, 6 or 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write request |
| reg_sel | input | 3 | Register select for the write |
| reg_wdata | input | 64 | Write data |
| reg_ready | output | 1 | Block can accept a write |
| px_valid | output | 1 | Pixel write strobe |
| px_x | output | 16 | Pixel X address |
| px_y | output | 16 | Pixel Y address |
| px_data | output | 32 | Pixel color |

## Verification
The bench sweeps every span value from 1 to 32 and also writes 0 and 33, checking each pixel's address and color and then checking that no pixel follows the last one. A design that handled the width field wrongly would issue one pixel too many or too few, or would draw nothing for a width of 0. A start coordinate near the X limit, with a negative Y step, exposes two faults: a carry from X into Y, and an X that stops at the end of the span instead of wrapping. Coordinate writes pushed in while a row is drawing, and writes to the unused selects, would show up as a displaced next row in a design that accepted them.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
   typedef enum logic [2:0] {
      SEL_COORD  = 3'd0,
      SEL_SPAN   = 3'd1,
      SEL_STEP   = 3'd2,
      SEL_COLORS = 3'd3,
      SEL_MASK   = 3'd4
   } glyph_sel_e;

   localparam int AXIS_X = 0;
   localparam int AXIS_Y = 1;
   localparam int N_AXES = 2;
endpackage

// File: rtl/glyph_regs.sv
module glyph_regs
   import glyph_pkg::*;
#(
   parameter int COORD_W = 16,
   parameter int PIX_W   = 32,
   parameter int MASK_W  = 32,
   parameter int SPAN_W  = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_fire,
   input  logic [2:0]           wr_sel,
   input  logic [2*PIX_W-1:0]   wr_data,
   input  logic                 row_done,
   output logic [COORD_W-1:0]   coord_x,
   output logic [COORD_W-1:0]   coord_y,
   output logic [SPAN_W-1:0]    span_field,
   output logic [PIX_W-1:0]     fg,
   output logic [PIX_W-1:0]     bg,
   output logic                 mask_start,
   output logic [MASK_W-1:0]    mask_word
);
   logic coord_wr, step_wr, span_wr, color_wr;
   logic [COORD_W-1:0] coord_q [N_AXES];
   logic [COORD_W-1:0] step_q  [N_AXES];

   assign coord_wr   = wr_fire && (wr_sel == SEL_COORD);
   assign step_wr    = wr_fire && (wr_sel == SEL_STEP);
   assign span_wr    = wr_fire && (wr_sel == SEL_SPAN);
   assign color_wr   = wr_fire && (wr_sel == SEL_COLORS);
   assign mask_start = wr_fire && (wr_sel == SEL_MASK);
   assign mask_word  = wr_data[MASK_W-1:0];

   for (genvar g = 0; g < N_AXES; g++) begin : g_axis
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            coord_q[g] <= '0;
            step_q[g]  <= (g == AXIS_Y) ? COORD_W'(1) : '0;
         end else begin
            if (coord_wr)
               coord_q[g] <= wr_data[g*COORD_W +: COORD_W];
            else if (row_done)
               coord_q[g] <= coord_q[g] + step_q[g];
            if (step_wr)
               step_q[g] <= wr_data[g*COORD_W +: COORD_W];
         end
      end

      AST_COORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!row_done && !coord_wr) |=> $stable(coord_q[g])); // R7
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         span_field <= '0;
         fg         <= '1;
         bg         <= '0;
      end else begin
         if (span_wr)
            span_field <= wr_data[SPAN_W-1:0];
         if (color_wr) begin
            fg <= wr_data[2*PIX_W-1:PIX_W];
            bg <= wr_data[PIX_W-1:0];
         end
      end
   end

   assign coord_x = coord_q[AXIS_X];
   assign coord_y = coord_q[AXIS_Y];
endmodule

// File: rtl/glyph_span.sv
module glyph_span #(
   parameter int MASK_W = 32,
   parameter int SPAN_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [MASK_W-1:0]  mask,
   input  logic [SPAN_W-1:0]  span_field,
   output logic               busy,
   output logic [SPAN_W-1:0]  col,
   output logic               cur_bit,
   output logic               row_done
);
   logic [MASK_W-1:0] sh;
   logic [SPAN_W-1:0] last_q;
   logic [SPAN_W:0]   run_cnt;

   assign row_done = busy && (col == last_q);
   assign cur_bit  = sh[MASK_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sh     <= '0;
         col    <= '0;
         last_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         sh     <= mask;
         col    <= '0;
         last_q <= span_field - SPAN_W'(1);
      end else if (busy) begin
         sh  <= sh << 1;
         col <= col + SPAN_W'(1);
         if (col == last_q)
            busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (start)
         run_cnt <= '0;
      else if (busy)
         run_cnt <= run_cnt + (SPAN_W+1)'(1);
   end

   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == ({1'b0, $past(last_q)} + (SPAN_W+1)'(1)))); // R6

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R8
endmodule

// File: rtl/glyph_expand_top.sv
module glyph_expand_top #(
   parameter int COORD_W = 16,
   parameter int PIX_W   = 32,
   parameter int MASK_W  = 32,
   parameter int OUT_REG = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [2:0]           reg_sel,
   input  logic [2*PIX_W-1:0]   reg_wdata,
   output logic                 reg_ready,
   output logic                 px_valid,
   output logic [COORD_W-1:0]   px_x,
   output logic [COORD_W-1:0]   px_y,
   output logic [PIX_W-1:0]     px_data
);
   localparam int SPAN_W = $clog2(MASK_W);

   if (MASK_W < 2 || (MASK_W & (MASK_W - 1)) != 0)
      $error("MASK_W must be a power of two of at least 2");
   if (COORD_W <= SPAN_W)
      $error("COORD_W must exceed the span index width");
   if (COORD_W > PIX_W || MASK_W > 2*PIX_W)
      $error("write data too narrow for coordinate or mask");
   if (OUT_REG < 0 || OUT_REG > 1)
      $error("OUT_REG must be 0 or 1");

   logic                wr_fire, mask_start, busy, cur_bit, row_done;
   logic [MASK_W-1:0]   mask_word;
   logic [SPAN_W-1:0]   span_field, col;
   logic [COORD_W-1:0]  coord_x, coord_y, x_c;
   logic [PIX_W-1:0]    fg, bg, pix_c;

   assign reg_ready = !busy;
   assign wr_fire   = reg_wr && reg_ready;

   glyph_regs #(
      .COORD_W(COORD_W), .PIX_W(PIX_W), .MASK_W(MASK_W), .SPAN_W(SPAN_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_sel(reg_sel),
      .wr_data(reg_wdata), .row_done(row_done),
      .coord_x(coord_x), .coord_y(coord_y), .span_field(span_field),
      .fg(fg), .bg(bg), .mask_start(mask_start), .mask_word(mask_word)
   );

   glyph_span #(
      .MASK_W(MASK_W), .SPAN_W(SPAN_W)
   ) i_span (
      .clk(clk), .rst_n(rst_n), .start(mask_start), .mask(mask_word),
      .span_field(span_field), .busy(busy), .col(col),
      .cur_bit(cur_bit), .row_done(row_done)
   );

   assign pix_c = cur_bit ? fg : bg;
   assign x_c   = coord_x + {{(COORD_W-SPAN_W){1'b0}}, col};

   if (OUT_REG == 0) begin : g_out_comb
      assign px_valid = busy;
      assign px_x     = x_c;
      assign px_y     = coord_y;
      assign px_data  = pix_c;
   end else begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            px_valid <= 1'b0;
            px_x     <= '0;
            px_y     <= '0;
            px_data  <= '0;
         end else begin
            px_valid <= busy;
            px_x     <= x_c;
            px_y     <= coord_y;
            px_data  <= pix_c;
         end
      end
   end

   AST_PIX_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid |-> (px_data == fg || px_data == bg)); // R5
endmodule

// File: tb/test_glyph_expand_top.sv
module test_glyph_expand_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [63:0] reg_wdata = '0;
   logic        reg_ready, px_valid;
   logic [15:0] px_x, px_y;
   logic [31:0] px_data;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [15:0] m_x, m_y, m_dx, m_dy;
   logic [31:0] m_fg, m_bg;
   int          m_w;

   always #5 clk = ~clk;

   glyph_expand_top i_glyph_expand_top (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_ready(reg_ready), .px_valid(px_valid),
      .px_x(px_x), .px_y(px_y), .px_data(px_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   // Draws one row and checks every pixel; poke=1 pushes a coordinate write
   // during the row which must be refused (R8).
   task automatic row(input logic [31:0] mask, input bit poke, input string req);
      logic [63:0] act, exp;
      wr(3'd4, {32'h0, mask});
      for (int k = 0; k < m_w; k++) begin
         @(negedge clk);
         act = {px_y, px_x, px_data};
         exp = {m_y, m_x + 16'(k), mask[31-k] ? m_fg : m_bg};
         chk(px_valid && act == exp, req, act, exp);
         chk(reg_ready == 1'b0, "R8 ready low while drawing", 64'(reg_ready), 64'd0);
         if (poke && k == 0) begin
            reg_wr = 1'b1; reg_sel = 3'd0; reg_wdata = 64'h0000_0000_7777_3333;
         end
         if (poke && k == 1) reg_wr = 1'b0;
      end
      @(negedge clk);
      chk(!px_valid && reg_ready, "R6 no pixel after span end",
          {62'd0, px_valid, reg_ready}, 64'd1);
      m_x = m_x + m_dx;
      m_y = m_y + m_dy;
   endtask

   task automatic set_coord(input logic [15:0] y, input logic [15:0] x);
      wr(3'd0, {32'h0, y, x});
      m_x = x; m_y = y;
   endtask

   task automatic set_step(input logic [15:0] dy, input logic [15:0] dx);
      wr(3'd2, {32'h0, dy, dx});
      m_dx = dx; m_dy = dy;
   endtask

   task automatic set_colors(input logic [31:0] f, input logic [31:0] b);
      wr(3'd3, {f, b});
      m_fg = f; m_bg = b;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] mk;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!px_valid && reg_ready, "R1 reset state",
          {62'd0, px_valid, reg_ready}, 64'd1);

      // R9: one row down per word; sweep of all span widths (R3 R4 R5 R6)
      set_step(16'h0001, 16'h0000);
      for (int w = 1; w <= 32; w++) begin
         wr(3'd1, 64'(w));
         m_w = w;
         set_coord(16'(w * 5), 16'(w * 7 + 100));
         set_colors(32'hA500_0000 + 32'(w), 32'h005A_0000 + 32'(w * 3));
         mk = (32'(w) * 32'h9E37_79B9) ^ {4{8'(w)}};
         row(mk, (w >= 2) && (w % 5 == 0), "R4 R5 R9 row one");
         row(~{mk[15:0], mk[31:16]}, 1'b0, "R3 R6 R9 row two");
      end

      // R6: explicit zero means full span, 33 wraps to one pixel
      wr(3'd1, 64'd0);  m_w = 32;
      row(32'hF0F0_1234, 1'b0, "R6 width zero");
      wr(3'd1, 64'd33); m_w = 1;
      row(32'h8000_0000, 1'b0, "R6 width 33");
      row(32'h7FFF_FFFF, 1'b0, "R6 width 33 clear bit");

      // R7: independent halves wrap, negative Y step
      wr(3'd1, 64'd4); m_w = 4;
      set_coord(16'h0002, 16'hFFFE);
      set_step(16'hFFFF, 16'h0003);
      row(32'hA000_0000, 1'b0, "R7 wrap row one");
      row(32'h5000_0000, 1'b0, "R7 wrap row two");
      row(32'hF000_0000, 1'b0, "R7 wrap row three");

      // R10: unused selects leave every register alone
      wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(3'd6, 64'h1234_5678_9ABC_DEF0);
      wr(3'd7, 64'h0F0F_0F0F_0F0F_0F0F);
      row(32'h6000_0000, 1'b0, "R10 unused select");

      // R2: colors updated through select 3 only
      set_colors(32'h0000_00FF, 32'hFF00_0000);
      row(32'h9000_0000, 1'b0, "R2 R5 color pair");

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule